// File: doc/BRIEF.md
# Two-Lane Shift-Mask-Add Interpolator

The block is a small register-mapped arithmetic unit that steps through tables and fixed-point sequences without processor arithmetic. It has two lanes. Each lane owns an accumulator, a base and a control word. A lane takes its own accumulator, or the accumulator of the other lane. It shifts that value right logically, keeps a chosen bit window, can sign-extend the window from its top bit, and adds the lane base. A third result, the full result, adds both lanes' windowed values to a third base.

A processor reaches the unit through a single-cycle write strobe and a read strobe. Read data is combinational. Peek addresses return a result and change nothing. Pop addresses return the same result and, at the clock edge, load both accumulators with the lane results, so that repeated pops walk a sequence. A build-time parameter gives the unit one of two special modes. Blend mode makes lane 1 interpolate linearly between the two lane bases. Clamp mode limits lane 0 to the range between those bases.

Top module: `shmask_interp`

## Requirements
- R1: Addresses (4 bits): 0 acc0, 1 acc1, 2 base0, 3 base1, 4 base2, 5 ctl0, 6 ctl1, 7 add0, 8 add1, 9 base pair (write only, reads 0), 10 peek lane0, 11 peek lane1, 12 peek full, 13 pop lane0, 14 pop lane1, 15 pop full. After reset every accumulator, base and control word reads 0. Writes to addresses 10 to 15 are ignored.
- R2: Control word bits: shift [4:0], window low bit [9:5], window high bit [14:10], sign-extend [15], cross source [16], cross writeback [17], raw add [18], top-or [20:19], blend [21], clamp [22]. A lane result is base plus (source >> shift) with only bits low..high kept. With ctl0 = 4<<10, acc0 = 0 and base0 = 1, a peek of lane 0 returns 1 and three pops of lane 0 return 1, 2 and 3.
- R3: With sign-extend set, every bit above the window high bit copies that bit before the base is added.
- R4: With cross source set, a lane uses the other lane's accumulator as its source. This also holds when raw add is set.
- R5: With raw add set, a lane result is base plus the unshifted source. The full result still uses the windowed value.
- R6: The top-or field is ORed into bits 29:28 of a lane result only on the read bus. A pop writes the result back without those bits.
- R7: A pop of any of the three pop addresses loads acc0 with lane 0's result and acc1 with lane 1's result on the same edge. With cross writeback set in a lane's control word, that lane's accumulator takes the other lane's result instead.
- R8: Reads of any address other than a pop address leave all state unchanged.
- R9: The full result is base2 plus the windowed values of both lanes.
- R10: Blend variant (LIMIT_MODE = 0), with ctl0 bit 21 set: lane 1 returns base0 + ((base1 - base0) * a) / 256, rounded toward minus infinity, where a is bits 7:0 of lane 1's windowed value. The bases are treated as signed when ctl1 bit 15 is set. Lane 0 omits base0, and the full result omits lane 1's value. In the clamp variant bit 21 is not stored and reads back as 0.
- R11: Clamp variant (LIMIT_MODE = 1), with ctl0 bit 22 set: lane 0 returns its windowed value limited to base0 from below first, then to base1 from above. The comparison is signed when ctl0 bit 15 is set. In the blend variant bit 22 is not stored and reads back as 0. Bits 21 and 22 of ctl1 are never stored.
- R12: A write to the base-pair address loads base0 from data bits 15:0 and base1 from data bits 31:16. Each half is sign-extended when that lane's sign-extend bit is set and zero-extended otherwise.
- R13: A write to add0 or add1 adds the data to that accumulator. A read of add0 or add1 returns that lane's windowed value with no base added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe; a pop takes effect with it |
| rd_addr | input | 4 | Read address |
| rd_data | output | 32 | Combinational read data |

## Verification
The assertions check on every cycle the properties that hold for any state. A pop loads each accumulator with the value the writeback selection chose. Reads that are not pops leave the accumulators alone. An add write sums into the accumulator. The top-or bits change nothing on the bus except bits 29:28. A clamped lane-0 result stays within ordered bases. The exact arithmetic can only be shown by the bench scenarios, which compare against an independent model: the shift and window, sign extension, cross feeding, raw add, the blend interpolation, base-pair loading, the variant-dependent storage of the mode bits, and the counting sequence of successive pops.

// File: rtl/itp_pkg.sv
package itp_pkg;
  localparam int DW    = 32;
  localparam int SHW   = $clog2(DW);
  localparam int LANES = 2;
  localparam int NBASE = 3;
  localparam int AW    = 4;
  localparam int CTLW  = 3 * SHW + 8;
  localparam int TOPB  = 28;

  typedef struct packed {
    logic           lim_en;
    logic           mix_en;
    logic [1:0]     top_or;
    logic           raw_add;
    logic           xwb;
    logic           xsrc;
    logic           sext_en;
    logic [SHW-1:0] hi_bit;
    logic [SHW-1:0] lo_bit;
    logic [SHW-1:0] sh_amt;
  } lane_ctl_t;

  typedef enum logic [AW-1:0] {
    A_ACC0 = 4'd0, A_ACC1 = 4'd1, A_BASE0 = 4'd2, A_BASE1 = 4'd3,
    A_BASE2 = 4'd4, A_CTL0 = 4'd5, A_CTL1 = 4'd6, A_ADD0 = 4'd7,
    A_ADD1 = 4'd8, A_BPAIR = 4'd9, A_PEEK0 = 4'd10, A_PEEK1 = 4'd11,
    A_PEEKF = 4'd12, A_POP0 = 4'd13, A_POP1 = 4'd14, A_POPF = 4'd15
  } reg_addr_e;

  // keep bits lo..hi of (v >> sh)
  function automatic logic [DW-1:0] f_shmask(input logic [DW-1:0] v,
      input logic [SHW-1:0] sh, input logic [SHW-1:0] lo, input logic [SHW-1:0] hi);
    logic [DW-1:0] t;
    logic [DW-1:0] r;
    t = v >> sh;
    for (int i = 0; i < DW; i++) begin
      r[i] = (i >= int'(lo)) && (i <= int'(hi)) && t[i];
    end
    return r;
  endfunction

  function automatic logic [DW-1:0] f_sext(input logic [DW-1:0] v,
      input logic [SHW-1:0] hi, input logic en);
    logic [DW-1:0] r;
    r = v;
    if (en && v[hi]) begin
      for (int i = 0; i < DW; i++) begin
        if (i > int'(hi)) r[i] = 1'b1;
      end
    end
    return r;
  endfunction

  function automatic logic [DW-1:0] f_half_ext(input logic [DW/2-1:0] h, input logic en);
    return {{(DW/2){en & h[DW/2-1]}}, h};
  endfunction

  // b0 + floor((b1-b0)*a/256)
  function automatic logic [DW-1:0] f_lerp(input logic [DW-1:0] b0,
      input logic [DW-1:0] b1, input logic [7:0] a, input logic sgn);
    logic signed [DW+1:0]  e0;
    logic signed [DW+1:0]  e1;
    logic signed [DW+1:0]  d;
    logic signed [DW+10:0] p;
    logic signed [DW+10:0] s;
    e0 = sgn ? $signed({{2{b0[DW-1]}}, b0}) : $signed({2'b00, b0});
    e1 = sgn ? $signed({{2{b1[DW-1]}}, b1}) : $signed({2'b00, b1});
    d  = e1 - e0;
    p  = $signed({{9{d[DW+1]}}, d}) * $signed({{(DW+3){1'b0}}, a});
    s  = p >>> 8;
    return b0 + s[DW-1:0];
  endfunction

  function automatic logic [DW-1:0] f_clamp(input logic [DW-1:0] v,
      input logic [DW-1:0] lo, input logic [DW-1:0] hi, input logic sgn);
    logic below;
    logic above;
    below = sgn ? ($signed(v) < $signed(lo)) : (v < lo);
    above = sgn ? ($signed(v) > $signed(hi)) : (v > hi);
    if (below) return lo;
    if (above) return hi;
    return v;
  endfunction
endpackage

// File: rtl/itp_lane_stage.sv
module itp_lane_stage
  import itp_pkg::*;
(
  input  lane_ctl_t     ctl,
  input  logic [DW-1:0] acc_own,
  input  logic [DW-1:0] acc_peer,
  output logic [DW-1:0] src,
  output logic [DW-1:0] win
);
  logic [DW-1:0] masked;

  assign src    = ctl.xsrc ? acc_peer : acc_own;
  assign masked = f_shmask(src, ctl.sh_amt, ctl.lo_bit, ctl.hi_bit);
  assign win    = f_sext(masked, ctl.hi_bit, ctl.sext_en);
endmodule

// File: rtl/itp_combine.sv
module itp_combine
  import itp_pkg::*;
#(
  parameter bit LIMIT_MODE = 1'b0
)(
  input  lane_ctl_t     ctl0,
  input  lane_ctl_t     ctl1,
  input  logic [DW-1:0] src0,
  input  logic [DW-1:0] src1,
  input  logic [DW-1:0] win0,
  input  logic [DW-1:0] win1,
  input  logic [DW-1:0] base0,
  input  logic [DW-1:0] base1,
  input  logic [DW-1:0] base2,
  output logic [DW-1:0] res0,
  output logic [DW-1:0] res1,
  output logic [DW-1:0] full,
  output logic          blend_on,
  output logic          clamp_on
);
  logic [DW-1:0] add0;
  logic [DW-1:0] add1;

  assign add0 = ctl0.raw_add ? src0 : win0;
  assign add1 = ctl1.raw_add ? src1 : win1;

  generate
    if (LIMIT_MODE) begin : g_clamp
      assign blend_on = 1'b0;
      assign clamp_on = ctl0.lim_en;
      assign res0 = clamp_on ? f_clamp(win0, base0, base1, ctl0.sext_en) : base0 + add0;
      assign res1 = base1 + add1;
      assign full = base2 + win0 + win1;
    end else begin : g_blend
      assign clamp_on = 1'b0;
      assign blend_on = ctl0.mix_en;
      assign res0 = blend_on ? add0 : base0 + add0;
      assign res1 = blend_on ? f_lerp(base0, base1, win1[7:0], ctl1.sext_en) : base1 + add1;
      assign full = blend_on ? base2 + win0 : base2 + win0 + win1;
    end
  endgenerate
endmodule

// File: rtl/shmask_interp.sv
module shmask_interp
  import itp_pkg::*;
#(
  parameter bit LIMIT_MODE = 1'b0
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  lane_ctl_t     ctl_q  [LANES];
  logic [DW-1:0] acc_q  [LANES];
  logic [DW-1:0] base_q [NBASE];
  logic [DW-1:0] src_w  [LANES];
  logic [DW-1:0] win_w  [LANES];
  logic [DW-1:0] res_w  [LANES];
  logic [DW-1:0] bus_w  [LANES];
  logic [DW-1:0] wb_w   [LANES];
  logic [DW-1:0] acc_d  [LANES];
  logic [DW-1:0] full_w;
  logic          blend_on;
  logic          clamp_on;
  logic          pop_fire;

  // named views for the checker
  logic [DW-1:0] acc0_v, acc1_v, wb0_v, wb1_v, res0_v, base0_v, base1_v;
  logic          sext0_v;

  function automatic lane_ctl_t f_ctl_keep(input logic [DW-1:0] d, input int lane);
    lane_ctl_t c;
    c = lane_ctl_t'(d[CTLW-1:0]);
    if (lane != 0 || LIMIT_MODE)  c.mix_en = 1'b0;
    if (lane != 0 || !LIMIT_MODE) c.lim_en = 1'b0;
    return c;
  endfunction

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      itp_lane_stage u_stage (
        .ctl      (ctl_q[g]),
        .acc_own  (acc_q[g]),
        .acc_peer (acc_q[LANES-1-g]),
        .src      (src_w[g]),
        .win      (win_w[g])
      );
      assign bus_w[g] = res_w[g] | ({{(DW-2){1'b0}}, ctl_q[g].top_or} << TOPB);
      assign wb_w[g]  = ctl_q[g].xwb ? res_w[LANES-1-g] : res_w[g];
    end
  endgenerate

  itp_combine #(.LIMIT_MODE(LIMIT_MODE)) u_comb (
    .ctl0     (ctl_q[0]),
    .ctl1     (ctl_q[1]),
    .src0     (src_w[0]),
    .src1     (src_w[1]),
    .win0     (win_w[0]),
    .win1     (win_w[1]),
    .base0    (base_q[0]),
    .base1    (base_q[1]),
    .base2    (base_q[2]),
    .res0     (res_w[0]),
    .res1     (res_w[1]),
    .full     (full_w),
    .blend_on (blend_on),
    .clamp_on (clamp_on)
  );

  assign pop_fire = rd_en && (rd_addr == A_POP0 || rd_addr == A_POP1 || rd_addr == A_POPF);

  // accumulator next value: pop writeback, then a direct write wins
  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      acc_d[l] = pop_fire ? wb_w[l] : acc_q[l];
      if (wr_en && wr_addr == AW'(int'(A_ACC0) + l)) acc_d[l] = wr_data;
      if (wr_en && wr_addr == AW'(int'(A_ADD0) + l)) acc_d[l] = acc_q[l] + wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int l = 0; l < LANES; l++) begin
        acc_q[l] <= '0;
        ctl_q[l] <= '0;
      end
      for (int b = 0; b < NBASE; b++) base_q[b] <= '0;
    end else begin
      for (int l = 0; l < LANES; l++) begin
        acc_q[l] <= acc_d[l];
        if (wr_en && wr_addr == AW'(int'(A_CTL0) + l)) ctl_q[l] <= f_ctl_keep(wr_data, l);
      end
      for (int b = 0; b < NBASE; b++) begin
        if (wr_en && wr_addr == AW'(int'(A_BASE0) + b)) base_q[b] <= wr_data;
      end
      if (wr_en && wr_addr == A_BPAIR) begin
        base_q[0] <= f_half_ext(wr_data[DW/2-1:0], ctl_q[0].sext_en);
        base_q[1] <= f_half_ext(wr_data[DW-1:DW/2], ctl_q[1].sext_en);
      end
    end
  end

  always_comb begin
    case (rd_addr)
      A_ACC0:          rd_data = acc_q[0];
      A_ACC1:          rd_data = acc_q[1];
      A_BASE0:         rd_data = base_q[0];
      A_BASE1:         rd_data = base_q[1];
      A_BASE2:         rd_data = base_q[2];
      A_CTL0:          rd_data = {{(DW-CTLW){1'b0}}, ctl_q[0]};
      A_CTL1:          rd_data = {{(DW-CTLW){1'b0}}, ctl_q[1]};
      A_ADD0:          rd_data = win_w[0];
      A_ADD1:          rd_data = win_w[1];
      A_PEEK0, A_POP0: rd_data = bus_w[0];
      A_PEEK1, A_POP1: rd_data = bus_w[1];
      A_PEEKF, A_POPF: rd_data = full_w;
      default:         rd_data = '0;
    endcase
  end

  assign acc0_v  = acc_q[0];
  assign acc1_v  = acc_q[1];
  assign wb0_v   = wb_w[0];
  assign wb1_v   = wb_w[1];
  assign res0_v  = res_w[0];
  assign base0_v = base_q[0];
  assign base1_v = base_q[1];
  assign sext0_v = ctl_q[0].sext_en;
endmodule

// File: rtl/shmask_interp_chk.sv
module shmask_interp_chk
  import itp_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          rd_en,
  input logic [AW-1:0] rd_addr,
  input logic [DW-1:0] rd_data,
  input logic          pop_fire,
  input logic [DW-1:0] acc0,
  input logic [DW-1:0] acc1,
  input logic [DW-1:0] wb0,
  input logic [DW-1:0] wb1,
  input logic [DW-1:0] res0,
  input logic [DW-1:0] base0,
  input logic [DW-1:0] base1,
  input logic          sext0,
  input logic          clamp_on
);
  assert_pop_writeback_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_fire && !wr_en) |=> (acc0 == $past(wb0) && acc1 == $past(wb1)));

  assert_peek_no_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!pop_fire && !wr_en) |=> ($stable(acc0) && $stable(acc1)));

  assert_add_sum_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_ADD0 && !pop_fire) |=> (acc0 == $past(acc0) + $past(wr_data)));

  assert_top_or_bus_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == A_PEEK0) |-> (rd_data[27:0] == res0[27:0] && rd_data[31:30] == res0[31:30]));

  assert_clamp_signed_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (clamp_on && sext0 && $signed(base0) <= $signed(base1))
      |-> ($signed(res0) >= $signed(base0) && $signed(res0) <= $signed(base1)));

  assert_clamp_unsigned_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (clamp_on && !sext0 && base0 <= base1) |-> (res0 >= base0 && res0 <= base1));
endmodule

bind shmask_interp shmask_interp_chk i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .rd_en    (rd_en),
  .rd_addr  (rd_addr),
  .rd_data  (rd_data),
  .pop_fire (pop_fire),
  .acc0     (acc0_v),
  .acc1     (acc1_v),
  .wb0      (wb0_v),
  .wb1      (wb1_v),
  .res0     (res0_v),
  .base0    (base0_v),
  .base1    (base1_v),
  .sext0    (sext0_v),
  .clamp_on (clamp_on)
);

// File: tb/test_shmask_interp.sv
module test_shmask_interp;
  import itp_pkg::*;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rdq0, rdq1;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // unit 0 is the blend variant, unit 1 the clamp variant
  bit [31:0] macc [2][2];
  bit [31:0] mbase[2][3];
  bit [31:0] mctl [2][2];

  always #(CLK_P/2) clk = ~clk;

  shmask_interp #(.LIMIT_MODE(1'b0)) i_shmask_interp (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rdq0));
  shmask_interp #(.LIMIT_MODE(1'b1)) i_shmask_interp_clamp (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rdq1));

  function automatic bit [31:0] m_win(int u, int l);
    bit [31:0] c, s, t, r;
    int lo, hi;
    c  = mctl[u][l];
    s  = c[16] ? macc[u][1-l] : macc[u][l];
    t  = s >> c[4:0];
    lo = int'(c[9:5]);
    hi = int'(c[14:10]);
    r  = 0;
    for (int i = lo; i <= hi; i++) r[i] = t[i];
    if (c[15] && r[hi]) for (int i = hi + 1; i < 32; i++) r[i] = 1'b1;
    return r;
  endfunction

  function automatic bit [31:0] m_lane(int u, int l);
    bit [31:0] c, s, v;
    longint b0, b1, pr;
    c = mctl[u][l];
    s = c[16] ? macc[u][1-l] : macc[u][l];
    v = c[18] ? s : m_win(u, l);
    if (u == 0 && mctl[0][0][21]) begin
      if (l == 0) return v;
      b0 = c[15] ? longint'($signed(mbase[u][0])) : longint'(mbase[u][0]);
      b1 = c[15] ? longint'($signed(mbase[u][1])) : longint'(mbase[u][1]);
      pr = (b1 - b0) * longint'(m_win(u, 1) & 32'hFF);
      pr = b0 + (pr >>> 8);
      return pr[31:0];
    end
    if (u == 1 && l == 0 && c[22]) begin
      v = m_win(u, 0);
      if (c[15]) begin
        if ($signed(v) < $signed(mbase[u][0])) return mbase[u][0];
        if ($signed(v) > $signed(mbase[u][1])) return mbase[u][1];
      end else begin
        if (v < mbase[u][0]) return mbase[u][0];
        if (v > mbase[u][1]) return mbase[u][1];
      end
      return v;
    end
    return mbase[u][l] + v;
  endfunction

  function automatic bit [31:0] m_full(int u);
    if (u == 0 && mctl[0][0][21]) return mbase[u][2] + m_win(u, 0);
    return mbase[u][2] + m_win(u, 0) + m_win(u, 1);
  endfunction

  function automatic bit [31:0] m_read(int u, int a);
    case (a)
      0, 1:    return macc[u][a];
      2, 3, 4: return mbase[u][a-2];
      5, 6:    return mctl[u][a-5];
      7, 8:    return m_win(u, a-7);
      10, 13:  return m_lane(u, 0) | {2'b0, mctl[u][0][20:19], 28'b0};
      11, 14:  return m_lane(u, 1) | {2'b0, mctl[u][1][20:19], 28'b0};
      12, 15:  return m_full(u);
      default: return 0;
    endcase
  endfunction

  function automatic void m_write(int u, int a, bit [31:0] d);
    bit [31:0] c;
    case (a)
      0, 1:    macc[u][a] = d;
      2, 3, 4: mbase[u][a-2] = d;
      5, 6: begin
        c = d & 32'h7F_FFFF;
        if (!(u == 0 && a == 5)) c[21] = 1'b0;
        if (!(u == 1 && a == 5)) c[22] = 1'b0;
        mctl[u][a-5] = c;
      end
      7, 8:    macc[u][a-7] = macc[u][a-7] + d;
      9: begin
        mbase[u][0] = {(mctl[u][0][15] && d[15]) ? 16'hFFFF : 16'h0, d[15:0]};
        mbase[u][1] = {(mctl[u][1][15] && d[31]) ? 16'hFFFF : 16'h0, d[31:16]};
      end
      default: ;
    endcase
  endfunction

  function automatic void m_pop(int u);
    bit [31:0] r0, r1;
    r0 = m_lane(u, 0);
    r1 = m_lane(u, 1);
    macc[u][0] = mctl[u][0][17] ? r1 : r0;
    macc[u][1] = mctl[u][1][17] ? r0 : r1;
  endfunction

  task automatic check(string req, bit [31:0] got, bit [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(int a, bit [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
    for (int u = 0; u < 2; u++) m_write(u, a, d);
  endtask

  task automatic rd(int a, output bit [31:0] r0, output bit [31:0] r1);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = 4'(a);
    #1 r0 = rdq0; r1 = rdq1;
    @(posedge clk);
    #1 rd_en = 1'b0;
    if (a >= 13) for (int u = 0; u < 2; u++) m_pop(u);
  endtask

  // compare a read of both units with the model
  task automatic rd_chk(int a, string tag);
    bit [31:0] e0, e1, g0, g1;
    e0 = m_read(0, a);
    e1 = m_read(1, a);
    rd(a, g0, g1);
    check(tag, g0, e0);
    check(tag, g1, e1);
  endtask

  task automatic check_all(string tag);
    for (int a = 0; a <= 12; a++) if (a != 9) rd_chk(a, tag);
  endtask

  task automatic clear_all();
    for (int a = 0; a <= 6; a++) wr(a, 0);
  endtask

  initial begin
    bit [31:0] g0, g1, ctl;
    int lo;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset values and map
    for (int a = 0; a <= 9; a++) begin
      rd(a, g0, g1);
      check("R1 reset", g0, 0);
      check("R1 reset", g1, 0);
    end
    wr(10, 32'h55); wr(13, 32'h66);
    check_all("R1 ignored write");

    // R2 counting sequence
    wr(5, 4 << 10); wr(0, 0); wr(2, 1);
    rd(10, g0, g1); check("R2 peek", g0, 1); check("R2 peek", g1, 1);
    for (int k = 1; k <= 3; k++) begin
      rd(13, g0, g1); check("R2 pop", g0, 32'(k)); check("R2 pop", g1, 32'(k));
    end
    // R8 peeks leave state alone
    rd(10, g0, g1); rd(11, g0, g1); rd(12, g0, g1);
    rd(0, g0, g1); check("R8 acc kept", g0, 3); check("R8 acc kept", g1, 3);

    // R6 top-or bits only on the bus
    wr(5, (4 << 10) | (3 << 19)); wr(0, 0);
    rd(10, g0, g1); check("R6 bus", g0, 32'h3000_0001); check("R6 bus", g1, 32'h3000_0001);
    rd(13, g0, g1); rd(0, g0, g1); check("R6 writeback", g0, 1); check("R6 writeback", g1, 1);

    // R3 sign extension
    clear_all(); wr(5, (7 << 10) | (1 << 15)); wr(0, 32'h80);
    rd(10, g0, g1); check("R3 sext", g0, 32'hFFFF_FF80); check("R3 sext", g1, 32'hFFFF_FF80);

    // R4 cross source, with and without raw add
    clear_all(); wr(6, (1 << 16) | (1 << 18) | (31 << 10)); wr(0, 32'h1234_5678); wr(3, 1);
    rd(11, g0, g1); check("R4 cross raw", g0, 32'h1234_5679);
    wr(6, (1 << 16) | (7 << 10) | 4);
    rd(11, g0, g1); check("R4 cross", g1, 32'h68);

    // R5 raw add leaves full alone
    clear_all(); wr(5, (1 << 18) | (3 << 10)); wr(0, 32'hFF);
    rd(10, g0, g1); check("R5 raw", g0, 32'hFF);
    rd(12, g0, g1); check("R5 full", g0, 32'hF); check("R5 full", g1, 32'hF);

    // R7 cross writeback
    clear_all(); wr(5, (1 << 17) | (31 << 10)); wr(6, 31 << 10);
    wr(0, 3); wr(1, 10); wr(2, 1); wr(3, 2);
    rd(15, g0, g1);
    rd(0, g0, g1); check("R7 acc0", g0, 12);
    rd(1, g0, g1); check("R7 acc1", g0, 12); check("R7 acc1", g1, 12);

    // R10 blend
    clear_all(); wr(5, (1 << 21) | (31 << 10)); wr(6, 7 << 10);
    wr(0, 32'h55); wr(1, 32'h80); wr(3, 200); wr(4, 1000);
    rd(10, g0, g1); check("R10 lane0", g0, 32'h55); check("R10 lane0", g1, 32'h55);
    rd(11, g0, g1); check("R10 lerp", g0, 100); check("R10 plain", g1, 328);
    rd(12, g0, g1); check("R10 full", g0, 1085); check("R10 full", g1, 1213);
    rd(5, g0, g1); check("R10 bit dropped", g1, 31 << 10);

    // R11 clamp
    clear_all(); wr(5, (1 << 22) | (31 << 10)); wr(2, 10); wr(3, 100); wr(0, 500);
    rd(10, g0, g1); check("R11 upper", g1, 100); check("R11 off", g0, 510);
    rd(5, g0, g1); check("R11 bit dropped", g0, 31 << 10);
    wr(0, 5);  rd(10, g0, g1); check("R11 lower", g1, 10);
    wr(0, 50); rd(10, g0, g1); check("R11 inside", g1, 50);
    wr(5, (1 << 22) | (1 << 15) | (31 << 10)); wr(2, 32'hFFFF_FFEC); wr(3, 20);
    wr(0, 32'hFFFF_FFF6); rd(10, g0, g1); check("R11 signed", g1, 32'hFFFF_FFF6);

    // R12 base pair
    clear_all(); wr(5, 1 << 15); wr(9, 32'h8001_FFFE);
    rd(2, g0, g1); check("R12 base0", g0, 32'hFFFF_FFFE);
    rd(3, g0, g1); check("R12 base1", g0, 32'h0000_8001);
    rd(9, g0, g1); check("R12 read zero", g0, 0);

    // R13 add register
    clear_all(); wr(5, 31 << 10); wr(0, 10); wr(7, 5);
    rd(0, g0, g1); check("R13 sum", g0, 15); check("R13 sum", g1, 15);
    wr(2, 100); rd(7, g0, g1); check("R13 raw read", g0, 15);

    // R9 and all modes: random configurations against the model
    for (int it = 0; it < 150; it++) begin
      for (int l = 0; l < 2; l++) begin
        lo  = int'($urandom % 32);
        ctl = ($urandom & 32'h7F_8000) | (32'(lo + int'($urandom % 32'(32 - lo))) << 10)
              | (32'(lo) << 5) | ($urandom % 32);
        wr(5 + l, ctl);
      end
      wr(0, $urandom); wr(1, $urandom);
      if (it % 4 == 0) wr(9, $urandom);
      else begin wr(2, $urandom); wr(3, $urandom); end
      wr(4, $urandom);
      if (it % 5 == 0) wr(7 + int'($urandom % 2), $urandom);
      check_all("R9 random");
      rd_chk(13 + int'($urandom % 3), "R7 random pop");
      rd_chk(0, "R7 random acc0");
      rd_chk(1, "R7 random acc1");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog got=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule